// File: doc/BRIEF.md
# Masked scalar FP32 square-root unit

This block takes the square root of the lowest 32-bit lane of a wide vector operand, treating that lane as an IEEE-754 single-precision number. It builds a complete destination vector around the scalar result. Two layouts of the upper lanes are supported:

- **Legacy two-operand form:** the old destination value is kept above bit 31.
- **Three-operand form:** bits 127:32 come from a first source, and everything above bit 127 is cleared.

In the three-operand form a one-bit write mask can suppress the scalar result. When it does, the low lane either keeps the old destination lane or becomes zero.

The rounding mode is chosen once per operation. A per-operation embedded field wins when it is enabled and the second source is a register. Otherwise the global rounding field is used. The mantissa root is produced by a restoring digit-by-digit recurrence at one result bit per cycle. A one-cycle start pulse latches every input. A one-cycle done pulse presents the destination vector together with the invalid, precision and denormal flags. Those outputs then hold until the next done.

Top module: `fsq_masked_unit`

## Requirements
- R1: For a positive normal input, bits 31:0 of the result hold the correctly rounded FP32 square root of `src2[31:0]`. Examples: 4.0 (0x40800000) gives 2.0 (0x40000000), 9.0 gives 3.0, and 0x7F7FFFFF gives 0x5F7FFFFF under round to nearest even.
- R2: The 2-bit rounding code means:
  - 00: round to nearest even.
  - 01: round toward negative infinity.
  - 10: round toward positive infinity.
  - 11: round toward zero.

  For input 2.0 these give 0x3FB504F3 for codes 00, 01 and 11, and 0x3FB504F4 for code 10. A round-up that carries out of the mantissa increments the exponent: 0x7F7FFFFF with code 10 gives 0x5F800000.
- R3: The rounding code is `emb_rnd` when `emb_rnd_en`=1 and `src2_in_reg`=1. In every other case it is `glob_rnd`.
- R4: Special inputs are handled as follows:
  - A quiet NaN is returned unchanged with no flag.
  - A signalling NaN is returned with bit 22 set and sets invalid.
  - Any negative nonzero value, including negative infinity, returns 0xFFC00000 and sets invalid.
  - +0 and -0 return themselves.
  - +infinity returns +infinity.
- R5: A positive subnormal input sets the denormal flag and is normalised before the root is taken. For example, 0x00000002 gives 0x1A800000, and 0x00400000 gives 0x1FB504F3 with precision also set. A negative subnormal only sets invalid, without denormal.
- R6: The precision flag is set exactly when the delivered root is inexact. It is never set together with invalid.
- R7: In the three-operand form (`three_op`=1), the computed root is written to bits 31:0 when `mask_on`=0, or when `mask_on`=1 and `mask_bit`=1.
- R8: In the three-operand form with `mask_on`=1 and `mask_bit`=0, bits 31:0 take one of two values:
  - `dst_prev[31:0]` when `zero_mask`=0.
  - Zero when `zero_mask`=1.

  In both cases all three flags are cleared, even for an input that would be invalid.
- R9: In the three-operand form, result bits 127:32 equal `src1[127:32]`, and every bit from 128 to VEC_W-1 is zero.
- R10: In the legacy form (`three_op`=0), result bits VEC_W-1:32 equal `dst_prev[VEC_W-1:32]`. The mask inputs have no effect, so the root is always written.
- R11: A start pulse latches all inputs. `done` is high for exactly one cycle, right after the 26th rising edge following the edge that sampled start. A start while an operation is in flight is ignored. Result and flags hold their values between done pulses.
- R12: While `rst_n` is low, and after it is released, `done`, the result and the flags are zero until the first done pulse. A reset during an operation cancels it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request; latches all operands and controls |
| three_op | input | 1 | 1 = three-operand form, 0 = legacy two-operand form |
| src1 | input | VEC_W | First source; bits 127:32 feed the three-operand result |
| src2 | input | VEC_W | Second source; bits 31:0 are the FP32 radicand |
| dst_prev | input | VEC_W | Previous destination value |
| mask_on | input | 1 | A write mask is in use (three-operand form only) |
| mask_bit | input | 1 | Mask bit 0; 1 enables the scalar write |
| zero_mask | input | 1 | 1 = zero the masked lane, 0 = keep the previous lane |
| emb_rnd_en | input | 1 | Per-operation rounding override enable |
| emb_rnd | input | 2 | Per-operation rounding code |
| src2_in_reg | input | 1 | Second source comes from a register |
| glob_rnd | input | 2 | Global rounding code |
| done | output | 1 | One-cycle pulse: result and flags valid |
| result | output | VEC_W | Assembled destination vector |
| flag_invalid | output | 1 | Invalid-operation flag |
| flag_precision | output | 1 | Inexact-result flag |
| flag_denormal | output | 1 | Denormal-operand flag |

## Verification
The bench builds the block with its default vector width of 256 bits. With that width, the region above bit 127 is large enough to show both behaviours of the upper lanes: three-operand results clear it, while legacy results carry it over from the previous destination. The floating-point widths are fixed by the format. A single width therefore reaches every rounding path, including the mantissa carry into the exponent at the largest finite input, and every special-value class.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

    localparam int FP_W    = 32;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int ROOT_W  = FRAC_W + 2;
    localparam int RAD_W   = 2 * ROOT_W;
    localparam int REM_W   = ROOT_W + 1;
    localparam int ITERS   = ROOT_W;
    localparam int CNT_W   = $clog2(ITERS);
    localparam int LZ_W    = $clog2(FRAC_W + 1);
    localparam int MID_W   = 128 - FP_W;

    localparam logic [FP_W-1:0] QNAN_DEFAULT = 32'hFFC0_0000;
    localparam logic [FP_W-1:0] PLUS_INF     = 32'h7F80_0000;
    localparam logic [FP_W-1:0] QUIET_BIT    = 32'h0040_0000;

    typedef enum logic [2:0] {
        OPK_NUM  = 3'd0,
        OPK_ZERO = 3'd1,
        OPK_INF  = 3'd2,
        OPK_QNAN = 3'd3,
        OPK_SNAN = 3'd4,
        OPK_NEG  = 3'd5
    } opnd_kind_e;

    typedef enum logic [1:0] {
        RND_EVEN = 2'b00,
        RND_DOWN = 2'b01,
        RND_UP   = 2'b10,
        RND_ZERO = 2'b11
    } rnd_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ITER   = 2'd1,
        PH_FINISH = 2'd2
    } phase_e;

endpackage

// File: rtl/fsq_classify.sv
module fsq_classify
    import fsq_pkg::*;
(
    input  logic [FP_W-1:0]   op,
    output opnd_kind_e        kind,
    output logic [ROOT_W-1:0] sig_even,
    output logic [EXP_W-1:0]  exp_root,
    output logic              denorm
);

    logic                    sgn;
    logic [EXP_W-1:0]        eb;
    logic [FRAC_W-1:0]       fr;
    logic                    is_sub;
    logic                    found;
    logic [LZ_W-1:0]         lead;
    logic [SIG_W-1:0]        sig;
    logic signed [9:0]       e_unb;
    logic signed [9:0]       e_ev;
    logic                    odd;

    always_comb begin
        sgn    = op[FP_W-1];
        eb     = op[FP_W-2:FRAC_W];
        fr     = op[FRAC_W-1:0];
        is_sub = (eb == '0) && (fr != '0);

        lead  = '0;
        found = 1'b0;
        for (int i = FRAC_W - 1; i >= 0; i--) begin
            if (!found && fr[i]) begin
                lead  = LZ_W'(FRAC_W - 1 - i);
                found = 1'b1;
            end
        end

        if (is_sub) begin
            sig   = {1'b0, fr} << (lead + LZ_W'(1));
            e_unb = -10'sd127 - $signed({5'b0, lead});
        end else begin
            sig   = {1'b1, fr};
            e_unb = $signed({2'b0, eb}) - 10'sd127;
        end

        odd      = e_unb[0];
        sig_even = odd ? {sig, 1'b0} : {1'b0, sig};
        e_ev     = odd ? (e_unb - 10'sd1) : e_unb;
        exp_root = EXP_W'((e_ev >>> 1) + 10'sd127);

        if (eb == '1) begin
            if (fr == '0) kind = sgn ? OPK_NEG : OPK_INF;
            else          kind = fr[FRAC_W-1] ? OPK_QNAN : OPK_SNAN;
        end else if ((eb == '0) && (fr == '0)) begin
            kind = OPK_ZERO;
        end else if (sgn) begin
            kind = OPK_NEG;
        end else begin
            kind = OPK_NUM;
        end

        denorm = is_sub && !sgn;
    end

endmodule

// File: rtl/fsq_root_step.sv
module fsq_root_step
    import fsq_pkg::*;
(
    input  logic [REM_W-1:0]  rem_in,
    input  logic [ROOT_W-1:0] q_in,
    input  logic [1:0]        pair,
    output logic [REM_W-1:0]  rem_out,
    output logic [ROOT_W-1:0] q_out
);

    logic [REM_W+1:0] wide;
    logic [REM_W+1:0] trial;
    logic             ge;

    always_comb begin
        wide    = {rem_in, pair};
        trial   = {1'b0, q_in, 2'b01};
        ge      = (wide >= trial);
        rem_out = ge ? REM_W'(wide - trial) : REM_W'(wide);
        q_out   = ROOT_W'({q_in, ge});
    end

endmodule

// File: rtl/fsq_round.sv
module fsq_round
    import fsq_pkg::*;
(
    input  opnd_kind_e        kind,
    input  logic [ROOT_W-1:0] root,
    input  logic              sticky,
    input  rnd_mode_e         rm,
    input  logic [EXP_W-1:0]  exp_root,
    input  logic [FP_W-1:0]   op,
    output logic [FP_W-1:0]   lane,
    output logic              inv,
    output logic              prec
);

    logic [SIG_W-1:0] mant;
    logic             guard;
    logic             inc;
    logic [SIG_W:0]   sum;
    logic             carry;
    logic [FRAC_W-1:0] frac;
    logic [EXP_W-1:0] exp_fin;
    logic             rnd_unused_top;

    assign rnd_unused_top = sum[SIG_W-1];

    always_comb begin
        mant  = root[ROOT_W-1:1];
        guard = root[0];
        case (rm)
            RND_EVEN: inc = guard && (sticky || mant[0]);
            RND_UP:   inc = guard || sticky;
            default:  inc = 1'b0;
        endcase
        sum     = {1'b0, mant} + {{SIG_W{1'b0}}, inc};
        carry   = sum[SIG_W];
        frac    = carry ? '0 : sum[FRAC_W-1:0];
        exp_fin = exp_root + {{(EXP_W-1){1'b0}}, carry};

        lane = op;
        inv  = 1'b0;
        prec = 1'b0;
        case (kind)
            OPK_NUM: begin
                lane = {1'b0, exp_fin, frac};
                prec = guard || sticky;
            end
            OPK_INF:  lane = PLUS_INF;
            OPK_SNAN: begin
                lane = op | QUIET_BIT;
                inv  = 1'b1;
            end
            OPK_NEG: begin
                lane = QNAN_DEFAULT;
                inv  = 1'b1;
            end
            default:  lane = op;
        endcase
    end

endmodule

// File: rtl/fsq_lane_merge.sv
module fsq_lane_merge
    import fsq_pkg::*;
#(
    parameter int VEC_W = 256
) (
    input  logic              three_op,
    input  logic              mask_on,
    input  logic              mask_bit,
    input  logic              zero_mask,
    input  logic [FP_W-1:0]   lane,
    input  logic [2:0]        flags,
    input  logic [MID_W-1:0]  src1_mid,
    input  logic [VEC_W-1:0]  dst_prev,
    output logic [VEC_W-1:0]  vec,
    output logic [2:0]        flags_o
);

    logic                    wr_en;
    logic [FP_W-1:0]         low;
    logic [VEC_W-FP_W-1:0]   upper_three;

    generate
        if (VEC_W > 128) begin : g_wide
            assign upper_three = {{(VEC_W-128){1'b0}}, src1_mid};
        end else begin : g_narrow
            assign upper_three = src1_mid;
        end
    endgenerate

    always_comb begin
        wr_en   = !three_op || !mask_on || mask_bit;
        low     = wr_en ? lane : (zero_mask ? '0 : dst_prev[FP_W-1:0]);
        vec     = {three_op ? upper_three : dst_prev[VEC_W-1:FP_W], low};
        flags_o = wr_en ? flags : 3'b000;
    end

endmodule

// File: rtl/fsq_masked_unit.sv
module fsq_masked_unit
    import fsq_pkg::*;
#(
    parameter int VEC_W = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             three_op,
    input  logic [VEC_W-1:0] src1,
    input  logic [VEC_W-1:0] src2,
    input  logic [VEC_W-1:0] dst_prev,
    input  logic             mask_on,
    input  logic             mask_bit,
    input  logic             zero_mask,
    input  logic             emb_rnd_en,
    input  logic [1:0]       emb_rnd,
    input  logic             src2_in_reg,
    input  logic [1:0]       glob_rnd,
    output logic             done,
    output logic [VEC_W-1:0] result,
    output logic             flag_invalid,
    output logic             flag_precision,
    output logic             flag_denormal
);

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic [RAD_W-1:0]   rad;
        logic [REM_W-1:0]   rem;
        logic [ROOT_W-1:0]  root;
        opnd_kind_e         kind;
        logic [EXP_W-1:0]   exp_root;
        logic [FP_W-1:0]    op;
        logic               den;
        rnd_mode_e          rm;
        logic               three;
        logic               m_on;
        logic               m_bit;
        logic               zmask;
        logic [MID_W-1:0]   s1_mid;
        logic [VEC_W-1:0]   dprev;
        logic [VEC_W-1:0]   res;
        logic               inv;
        logic               prec;
        logic               dflag;
        logic               done;
    } st_t;

    st_t st_d, st_q;

    opnd_kind_e        cls_kind;
    logic [ROOT_W-1:0] cls_sig;
    logic [EXP_W-1:0]  cls_exp;
    logic              cls_den;
    logic [REM_W-1:0]  stp_rem;
    logic [ROOT_W-1:0] stp_q;
    logic [FP_W-1:0]   rnd_lane;
    logic              rnd_inv;
    logic              rnd_prec;
    logic [VEC_W-1:0]  mrg_vec;
    logic [2:0]        mrg_flags;
    logic              sig_unused_lo;

    assign sig_unused_lo = ^{src1[FP_W-1:0], src2[VEC_W-1:FP_W]};

    generate
        if (VEC_W > 128) begin : g_src1_hi
            logic sig_unused_hi;
            assign sig_unused_hi = ^src1[VEC_W-1:128];
        end
    endgenerate

    fsq_classify u_classify (
        .op       (src2[FP_W-1:0]),
        .kind     (cls_kind),
        .sig_even (cls_sig),
        .exp_root (cls_exp),
        .denorm   (cls_den)
    );

    fsq_root_step u_step (
        .rem_in  (st_q.rem),
        .q_in    (st_q.root),
        .pair    (st_q.rad[RAD_W-1 -: 2]),
        .rem_out (stp_rem),
        .q_out   (stp_q)
    );

    fsq_round u_round (
        .kind     (st_q.kind),
        .root     (st_q.root),
        .sticky   (st_q.rem != '0),
        .rm       (st_q.rm),
        .exp_root (st_q.exp_root),
        .op       (st_q.op),
        .lane     (rnd_lane),
        .inv      (rnd_inv),
        .prec     (rnd_prec)
    );

    fsq_lane_merge #(.VEC_W(VEC_W)) u_merge (
        .three_op  (st_q.three),
        .mask_on   (st_q.m_on),
        .mask_bit  (st_q.m_bit),
        .zero_mask (st_q.zmask),
        .lane      (rnd_lane),
        .flags     ({rnd_inv, rnd_prec, st_q.den}),
        .src1_mid  (st_q.s1_mid),
        .dst_prev  (st_q.dprev),
        .vec       (mrg_vec),
        .flags_o   (mrg_flags)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase    = PH_ITER;
                    st_d.cnt      = '0;
                    st_d.rad      = {cls_sig, {ROOT_W{1'b0}}};
                    st_d.rem      = '0;
                    st_d.root     = '0;
                    st_d.kind     = cls_kind;
                    st_d.exp_root = cls_exp;
                    st_d.op       = src2[FP_W-1:0];
                    st_d.den      = cls_den;
                    st_d.rm       = rnd_mode_e'((emb_rnd_en && src2_in_reg) ? emb_rnd : glob_rnd);
                    st_d.three    = three_op;
                    st_d.m_on     = mask_on;
                    st_d.m_bit    = mask_bit;
                    st_d.zmask    = zero_mask;
                    st_d.s1_mid   = src1[127:FP_W];
                    st_d.dprev    = dst_prev;
                end
            end
            PH_ITER: begin
                st_d.rem  = stp_rem;
                st_d.root = stp_q;
                st_d.rad  = st_q.rad << 2;
                st_d.cnt  = st_q.cnt + CNT_W'(1);
                if (st_q.cnt == CNT_W'(ITERS - 1)) st_d.phase = PH_FINISH;
            end
            PH_FINISH: begin
                st_d.res   = mrg_vec;
                st_d.inv   = mrg_flags[2];
                st_d.prec  = mrg_flags[1];
                st_d.dflag = mrg_flags[0];
                st_d.done  = 1'b1;
                st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done           = st_q.done;
    assign result         = st_q.res;
    assign flag_invalid   = st_q.inv;
    assign flag_precision = st_q.prec;
    assign flag_denormal  = st_q.dflag;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_FINISH) |=> $stable(result)); // R11

    AST_INVALID_GIVES_QNAN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_invalid) |-> (result[30:22] == 9'h1FF)); // R4

    AST_PREC_NOT_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_precision) |-> !flag_invalid); // R6

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_q.three && st_q.m_on && !st_q.m_bit) |->
        (!flag_invalid && !flag_precision && !flag_denormal)); // R8

    generate
        if (VEC_W > 128) begin : g_top_chk
            AST_WIDE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                (done && st_q.three) |-> (result[VEC_W-1:128] == '0)); // R9
        end
    endgenerate

endmodule

// File: tb/fsq_masked_unit_tb.sv
module fsq_masked_unit_tb;

    localparam int VEC_W   = 256;
    localparam int LAT     = 26;
    localparam int NVEC    = 30;

    typedef struct packed {
        logic [31:0] a;
        logic [11:0] c;
        logic [31:0] e;
        logic [3:0]  f;
        logic [3:0]  r;
    } vec_t;

    // c: [11]three [10]mask_on [9]mask_bit [8]zero [7]emb_en [6]in_reg [5:4]emb [3:2]glob
    // f: {0, invalid, precision, denormal}
    localparam vec_t VT [NVEC] = '{
        {32'h40800000, 12'h800, 32'h40000000, 4'h0, 4'd9},
        {32'h3F800000, 12'h000, 32'h3F800000, 4'h0, 4'd10},
        {32'h40000000, 12'h800, 32'h3FB504F3, 4'h2, 4'd1},
        {32'h40000000, 12'h80C, 32'h3FB504F3, 4'h2, 4'd2},
        {32'h40000000, 12'h808, 32'h3FB504F4, 4'h2, 4'd2},
        {32'h40000000, 12'h804, 32'h3FB504F3, 4'h2, 4'd2},
        {32'h40000000, 12'h8E0, 32'h3FB504F4, 4'h2, 4'd3},
        {32'h40000000, 12'h8A0, 32'h3FB504F3, 4'h2, 4'd3},
        {32'h40000000, 12'h8C8, 32'h3FB504F3, 4'h2, 4'd3},
        {32'h41100000, 12'h000, 32'h40400000, 4'h0, 4'd1},
        {32'h3E800000, 12'h800, 32'h3F000000, 4'h0, 4'd6},
        {32'h00000000, 12'h800, 32'h00000000, 4'h0, 4'd4},
        {32'h80000000, 12'h800, 32'h80000000, 4'h0, 4'd4},
        {32'h7F800000, 12'h800, 32'h7F800000, 4'h0, 4'd4},
        {32'hFF800000, 12'h800, 32'hFFC00000, 4'h4, 4'd4},
        {32'hBF800000, 12'h800, 32'hFFC00000, 4'h4, 4'd6},
        {32'h7FC12345, 12'h800, 32'h7FC12345, 4'h0, 4'd4},
        {32'h7F812345, 12'h800, 32'h7FC12345, 4'h4, 4'd4},
        {32'h00000002, 12'h800, 32'h1A800000, 4'h1, 4'd5},
        {32'h00400000, 12'h800, 32'h1FB504F3, 4'h3, 4'd5},
        {32'h80000001, 12'h800, 32'hFFC00000, 4'h4, 4'd5},
        {32'h7F7FFFFF, 12'h800, 32'h5F7FFFFF, 4'h2, 4'd1},
        {32'h7F7FFFFF, 12'h808, 32'h5F800000, 4'h2, 4'd2},
        {32'h3F800000, 12'h800, 32'h3F800000, 4'h0, 4'd7},
        {32'h40000000, 12'hE00, 32'h3FB504F3, 4'h2, 4'd7},
        {32'h40800000, 12'hC00, 32'hC3C3C3C3, 4'h0, 4'd8},
        {32'h40800000, 12'hD00, 32'h00000000, 4'h0, 4'd8},
        {32'hBF800000, 12'hC00, 32'hC3C3C3C3, 4'h0, 4'd8},
        {32'h00000002, 12'hD00, 32'h00000000, 4'h0, 4'd8},
        {32'h40800000, 12'h500, 32'h40000000, 4'h0, 4'd10}
    };

    localparam logic [VEC_W-1:0] S1 = {4{64'h13579BDF_2468ACE0}};
    localparam logic [VEC_W-1:0] DP = {4{64'hD0D0D0D0_C3C3C3C3}};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             three_op = 1'b0;
    logic [VEC_W-1:0] src1 = '0;
    logic [VEC_W-1:0] src2 = '0;
    logic [VEC_W-1:0] dst_prev = '0;
    logic             mask_on = 1'b0;
    logic             mask_bit = 1'b0;
    logic             zero_mask = 1'b0;
    logic             emb_rnd_en = 1'b0;
    logic [1:0]       emb_rnd = 2'b00;
    logic             src2_in_reg = 1'b0;
    logic [1:0]       glob_rnd = 2'b00;
    logic             done;
    logic [VEC_W-1:0] result;
    logic             flag_invalid;
    logic             flag_precision;
    logic             flag_denormal;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    fsq_masked_unit #(.VEC_W(VEC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .three_op(three_op),
        .src1(src1), .src2(src2), .dst_prev(dst_prev),
        .mask_on(mask_on), .mask_bit(mask_bit), .zero_mask(zero_mask),
        .emb_rnd_en(emb_rnd_en), .emb_rnd(emb_rnd), .src2_in_reg(src2_in_reg),
        .glob_rnd(glob_rnd), .done(done), .result(result),
        .flag_invalid(flag_invalid), .flag_precision(flag_precision),
        .flag_denormal(flag_denormal)
    );

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            4'd10: return "R10";
            4'd11: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string req, input logic [VEC_W+2:0] act,
                         input logic [VEC_W+2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        src1        = S1;
        dst_prev    = DP;
        src2        = {{7{32'h0BADF00D}}, v.a};
        three_op    = v.c[11];
        mask_on     = v.c[10];
        mask_bit    = v.c[9];
        zero_mask   = v.c[8];
        emb_rnd_en  = v.c[7];
        src2_in_reg = v.c[6];
        emb_rnd     = v.c[5:4];
        glob_rnd    = v.c[3:2];
    endtask

    // Starts an operation and returns the number of falling edges until done is seen.
    task automatic run_op(input vec_t v, output int n);
        @(negedge clk);
        drive(v);
        start = 1'b1;
        n = 0;
        while (n < 200) begin
            @(negedge clk);
            start = 1'b0;
            n++;
            if (done) break;
        end
    endtask

    function automatic logic [VEC_W-1:0] expect_vec(input vec_t v);
        if (v.c[11]) return {128'b0, S1[127:32], v.e};
        else         return {DP[VEC_W-1:32], v.e};
    endfunction

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", {done, result, flag_invalid, flag_precision, flag_denormal}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", {done, result, flag_invalid, flag_precision, flag_denormal}, '0);

        for (int i = 0; i < NVEC; i++) begin
            run_op(VT[i], n);
            check(req_name(VT[i].r),
                  {result, flag_invalid, flag_precision, flag_denormal},
                  {1'b0, expect_vec(VT[i]), VT[i].f[2:0]});
        end

        // R11: latency of done after the sampling edge
        run_op(VT[0], n);
        check("R11", (VEC_W+3)'(n - 1), (VEC_W+3)'(LAT));

        // R11: result and flags hold with no start while inputs change
        repeat (3) @(negedge clk);
        drive(VT[14]);
        repeat (4) @(negedge clk);
        check("R11", {result, flag_invalid, flag_precision, flag_denormal},
              {1'b0, expect_vec(VT[0]), 3'b000});

        // R11: start while busy is ignored
        begin
            int edges;
            int dones;
            @(negedge clk);
            drive(VT[0]);
            start = 1'b1;
            edges = 0;
            dones = 0;
            n = 0;
            while (edges < 70) begin
                @(negedge clk);
                edges++;
                start = (edges == 5);
                if (edges == 5) drive(VT[2]);
                if (done) begin
                    dones++;
                    n = edges;
                    check("R11", {result, flag_invalid, flag_precision, flag_denormal},
                          {1'b0, expect_vec(VT[0]), 3'b000});
                end
            end
            start = 1'b0;
            check("R11", (VEC_W+3)'(dones), (VEC_W+3)'(1));
            check("R11", (VEC_W+3)'(n - 1), (VEC_W+3)'(LAT));
        end

        // R12: reset during an operation cancels it and clears outputs
        @(negedge clk);
        drive(VT[2]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R12", {done, result, flag_invalid, flag_precision, flag_denormal}, '0);
        rst_n = 1'b1;
        begin
            int seen = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (done) seen++;
            end
            check("R12", (VEC_W+3)'(seen), '0);
        end
        check("R12", {done, result, flag_invalid, flag_precision, flag_denormal}, '0);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R11 watchdog actual=hung expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule